// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block protects a data word on its way into and out of storage. On the write side it takes a data word and forms a code word: the data bits are spread over the non-power-of-two positions of a Hamming word, check bits fill the power-of-two positions, and one extra bit appended at the right end gives the whole word even parity. On the read side it takes a code word that may have been disturbed, works out the syndrome and the whole-word parity, repairs a single flipped bit, and raises one of two flags. A single flag means that one bit was repaired. A double flag means that the word is not trustworthy.

The data width is a parameter. The number of check bits is the smallest count `p` for which `2^p >= p + DATA_W + 1`. The default is 4 data bits in an 8-bit word, and a 64-bit configuration gives a 72-bit word. The write path is combinational. The read path can end in an output register or be purely combinational, as a parameter selects.

Top module: `secded_codec`

## Requirements
- R1: Code word positions are numbered from 1 at the MSB of the code word. For 4 data bits, positions 1..8 hold p1 p2 d1 p3 d2 d3 d4 and the overall parity bit. Here d1 is the MSB of `wr_data` and the overall parity bit is `wr_code[0]`. In general, data bits fill the non-power-of-two positions in order, MSB first.
- R2: The check bit at position 2^j gives even parity over every position whose index has bit j set. For 4 data bits, p1 covers 1,3,5,7, p2 covers 2,3,6,7 and p3 covers 4,5,6,7.
- R3: The overall parity bit makes the whole code word even parity.
- R4: The check-bit count is the smallest p with 2^p >= p+DATA_W+1, and the code word has DATA_W+p+1 bits. This gives 8 bits for 4 data bits and 72 bits for 64 data bits. Every single flip of a 72-bit word is repaired.
- R5: A code word read back unchanged returns its data with both flags low.
- R6: A code word with one flipped data-position bit returns the original data with `rd_single` high and `rd_double` low.
- R7: A code word with one flipped check-position bit returns the original data with `rd_single` high.
- R8: A code word whose only flipped bit is the overall parity bit returns the original data with `rd_single` high.
- R9: A code word with two flipped bits raises `rd_double` and drops `rd_single`. The data bits are passed through uncorrected, exactly as they sit in the received word.
- R10: With `REG_OUT=1` (the default), the read outputs appear one clock after `rd_code` is sampled, and reset clears them to zero. With `REG_OUT=0`, they follow `rd_code` with no clock.
- R11: `rd_single` and `rd_double` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional read output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | DATA_W | Data word to encode |
| wr_code | output | CODE_W | Encoded word (combinational) |
| rd_code | input | CODE_W | Received code word to check |
| rd_data | output | DATA_W | Repaired (or passed-through) data |
| rd_single | output | 1 | One bit was flipped and has been repaired |
| rd_double | output | 1 | Two bits were flipped; data not repaired |

## Verification
The assertions assume that `rd_code` and `wr_data` change only away from the rising clock edge. They also assume that a read word equal to the encoder's current output is a clean round trip. The flag rules assume that a disturbed word carries at most two flipped bits, since three or more flips may alias to a single-error syndrome. The stimulus therefore builds every read word from an encoding of known data with zero, one or two chosen bit flips, and drives it on the falling edge.

// File: rtl/secded_pkg.sv
package secded_pkg;

  // Smallest check-bit count p with 2^p >= p + d + 1.
  function automatic int chk_bits(input int d);
    int p;
    p = 1;
    while ((1 << p) < p + d + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction

  // Hamming position (1-based) of the k-th data bit, k = 0 being the MSB.
  function automatic int data_pos(input int k);
    int cnt;
    int pos;
    cnt = 0;
    pos = 0;
    for (int i = 1; i < 4096; i++) begin
      if (!is_pow2(i)) begin
        if (cnt == k) begin
          pos = i;
          break;
        end
        cnt++;
      end
    end
    return pos;
  endfunction

  // True when position pos belongs to the parity group of check bit j.
  function automatic bit covers(input int pos, input int j);
    return ((pos >> j) & 1) == 1;
  endfunction

endpackage

// File: rtl/secded_enc.sv
module secded_enc import secded_pkg::*; #(
  parameter  int DATA_W = 4,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int HAM_W  = DATA_W + CHK_W,
  localparam int CODE_W = HAM_W + 1
) (
  input  logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] code
);

  logic [HAM_W:1] placed;
  logic [HAM_W:1] full;

  for (genvar k = 0; k < DATA_W; k++) begin : g_place
    localparam int P = data_pos(k);
    assign placed[P] = data[DATA_W-1-k];
  end
  for (genvar j = 0; j < CHK_W; j++) begin : g_hole
    assign placed[1 << j] = 1'b0;
  end

  always_comb begin
    full = placed;
    for (int j = 0; j < CHK_W; j++) begin
      full[1 << j] = 1'b0;
      for (int pos = 1; pos <= HAM_W; pos++) begin
        if (covers(pos, j)) full[1 << j] = full[1 << j] ^ placed[pos];
      end
    end
  end

  for (genvar pos = 1; pos <= HAM_W; pos++) begin : g_out
    assign code[CODE_W-pos] = full[pos];
  end
  assign code[0] = ^full;

endmodule

// File: rtl/secded_syndrome.sv
module secded_syndrome import secded_pkg::*; #(
  parameter  int DATA_W = 4,
  localparam int CHK_W  = chk_bits(DATA_W),
  localparam int HAM_W  = DATA_W + CHK_W,
  localparam int CODE_W = HAM_W + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic [CHK_W-1:0]  syn,
  output logic              ovr
);

  logic [HAM_W:1] hv;

  for (genvar pos = 1; pos <= HAM_W; pos++) begin : g_in
    assign hv[pos] = code[CODE_W-pos];
  end

  always_comb begin
    syn = '0;
    for (int j = 0; j < CHK_W; j++) begin
      for (int pos = 1; pos <= HAM_W; pos++) begin
        if (covers(pos, j)) syn[j] = syn[j] ^ hv[pos];
      end
    end
  end

  assign ovr = ^code;

endmodule

// File: rtl/secded_dec.sv
module secded_dec import secded_pkg::*; #(
  parameter  int DATA_W  = 4,
  parameter  bit REG_OUT = 1'b1,
  localparam int CHK_W   = chk_bits(DATA_W),
  localparam int HAM_W   = DATA_W + CHK_W,
  localparam int CODE_W  = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic [CHK_W-1:0]  syn,
  input  logic              ovr,
  output logic [DATA_W-1:0] data,
  output logic              err_one,
  output logic              err_two
);

  logic [HAM_W:1]    hv;
  logic [HAM_W:1]    fixed;
  logic [DATA_W-1:0] data_c;
  logic              in_range;
  logic              one_c;
  logic              two_c;

  for (genvar pos = 1; pos <= HAM_W; pos++) begin : g_in
    assign hv[pos] = code[CODE_W-pos];
  end

  // A syndrome naming a position past the word cannot be one flip.
  assign in_range = int'(syn) <= HAM_W;
  assign one_c    = ovr && in_range;
  assign two_c    = (syn != '0) && (!ovr || !in_range);

  always_comb begin
    fixed = hv;
    for (int pos = 1; pos <= HAM_W; pos++) begin
      if (one_c && int'(syn) == pos) fixed[pos] = ~hv[pos];
    end
  end

  for (genvar k = 0; k < DATA_W; k++) begin : g_pick
    localparam int P = data_pos(k);
    assign data_c[DATA_W-1-k] = fixed[P];
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data    <= '0;
        err_one <= 1'b0;
        err_two <= 1'b0;
      end else begin
        data    <= data_c;
        err_one <= one_c;
        err_two <= two_c;
      end
    end
  end else begin : g_comb
    assign data    = data_c;
    assign err_one = one_c;
    assign err_two = two_c;
  end

endmodule

// File: rtl/secded_codec.sv
module secded_codec import secded_pkg::*; #(
  parameter  int DATA_W  = 4,
  parameter  bit REG_OUT = 1'b1,
  localparam int CHK_W   = chk_bits(DATA_W),
  localparam int CODE_W  = DATA_W + CHK_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CODE_W-1:0] wr_code,
  input  logic [CODE_W-1:0] rd_code,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_single,
  output logic              rd_double
);

  logic [CHK_W-1:0] rd_syn;
  logic             rd_ovr;

  secded_enc #(.DATA_W(DATA_W)) u_enc (
    .data (wr_data),
    .code (wr_code)
  );

  secded_syndrome #(.DATA_W(DATA_W)) u_syn (
    .code (rd_code),
    .syn  (rd_syn),
    .ovr  (rd_ovr)
  );

  secded_dec #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .code    (rd_code),
    .syn     (rd_syn),
    .ovr     (rd_ovr),
    .data    (rd_data),
    .err_one (rd_single),
    .err_two (rd_double)
  );

endmodule

// File: rtl/secded_codec_chk.sv
module secded_codec_chk import secded_pkg::*; #(
  parameter  int DATA_W  = 4,
  parameter  bit REG_OUT = 1'b1,
  localparam int CHK_W   = chk_bits(DATA_W),
  localparam int CODE_W  = DATA_W + CHK_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] wr_data,
  input logic [CODE_W-1:0] wr_code,
  input logic [CODE_W-1:0] rd_code,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_single,
  input logic              rd_double,
  input logic [CHK_W-1:0]  rd_syn,
  input logic              rd_ovr
);

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_single && rd_double));

  a_r2_encoded_word_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_code == wr_code) |-> (rd_syn == '0 && !rd_ovr));

  if (REG_OUT) begin : g_seq
    a_r5_round_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_code == wr_code) |=> (rd_data == $past(wr_data) && !rd_single && !rd_double));
    a_r9_double_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_syn != '0 && !rd_ovr) |=> (rd_double && !rd_single));
    a_r8_parity_only: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_syn == '0 && rd_ovr) |=> (rd_single && !rd_double));
  end else begin : g_comb
    a_r5_round_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_code == wr_code) |-> (rd_data == wr_data && !rd_single && !rd_double));
    a_r9_double_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_syn != '0 && !rd_ovr) |-> (rd_double && !rd_single));
    a_r8_parity_only: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_syn == '0 && rd_ovr) |-> (rd_single && !rd_double));
  end

endmodule

bind secded_codec secded_codec_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_data   (wr_data),
  .wr_code   (wr_code),
  .rd_code   (rd_code),
  .rd_data   (rd_data),
  .rd_single (rd_single),
  .rd_double (rd_double),
  .rd_syn    (rd_syn),
  .rd_ovr    (rd_ovr)
);

// File: tb/secded_codec_test.sv
module secded_codec_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  wr_data = '0;
  logic [7:0]  wr_code;
  logic [7:0]  rd_code = 8'hFF;
  logic [3:0]  rd_data;
  logic        rd_single, rd_double;

  logic [63:0] w_data = '0;
  logic [71:0] w_code;
  logic [71:0] w_rd = '0;
  logic [63:0] w_out;
  logic        w_single, w_double;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  secded_codec #(.DATA_W(4), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
    .rd_code(rd_code), .rd_data(rd_data), .rd_single(rd_single), .rd_double(rd_double));

  secded_codec #(.DATA_W(64), .REG_OUT(1'b0)) uut_w (
    .clk(clk), .rst_n(rst_n), .wr_data(w_data), .wr_code(w_code),
    .rd_code(w_rd), .rd_data(w_out), .rd_single(w_single), .rd_double(w_double));

  // Bench encoding: d1 = MSB; word = p1 p2 d1 p3 d2 d3 d4 then overall parity.
  function automatic logic [7:0] enc4(input logic [3:0] d);
    logic p1, p2, p3;
    logic [6:0] w;
    p1 = d[3] ^ d[2] ^ d[0];
    p2 = d[3] ^ d[1] ^ d[0];
    p3 = d[2] ^ d[1] ^ d[0];
    w  = {p1, p2, d[3], p3, d[2], d[1], d[0]};
    return {w, ^w};
  endfunction

  // Data bits as found in positions 3,5,6,7 of a word.
  function automatic logic [3:0] raw4(input logic [7:0] c);
    return {c[5], c[3], c[2], c[1]};
  endfunction

  function automatic logic [7:0] flip_at(input int pos);
    return 8'h80 >> (pos - 1);
  endfunction

  task automatic chk(input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read4(input logic [3:0] d, input logic [7:0] c);
    @(negedge clk);
    wr_data = d;
    rd_code = c;
    @(negedge clk);
  endtask

  task automatic summary;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset holds registered outputs at zero even with a valid word present
    chk("R10 reset data", {68'd0, rd_data}, 72'd0);
    chk("R10 reset flags", {70'd0, rd_single, rd_double}, 72'd0);
    rst_n = 1'b1;

    // R1 R2 R3: encoder against bench encoding for every data value
    for (int d = 0; d < 16; d++) begin
      @(negedge clk);
      wr_data = 4'(d);
      #1;
      chk("R1 R2 layout and groups", {64'd0, wr_code}, {64'd0, enc4(4'(d))});
      chk("R3 whole word even", {71'd0, ^wr_code}, 72'd0);
    end

    // R10 latency: output still old just after the drive, new after one edge
    read4(4'h0, enc4(4'h0));
    @(negedge clk);
    rd_code = enc4(4'hB);
    #1;
    chk("R10 no change before edge", {68'd0, rd_data}, 72'd0);
    @(negedge clk);
    chk("R10 one clock later", {68'd0, rd_data}, {68'd0, 4'hB});

    // R5..R8 directed on every data value and every single position
    for (int d = 0; d < 16; d++) begin
      read4(4'(d), enc4(4'(d)));
      chk("R5 clean data", {68'd0, rd_data}, {68'd0, 4'(d)});
      chk("R5 clean flags", {70'd0, rd_single, rd_double}, 72'd0);
      for (int pos = 1; pos <= 8; pos++) begin
        read4(4'(d), enc4(4'(d)) ^ flip_at(pos));
        if (pos == 8) begin
          chk("R8 parity-only data", {68'd0, rd_data}, {68'd0, 4'(d)});
          chk("R8 parity-only flags", {70'd0, rd_single, rd_double}, 72'd2);
        end else if (pos == 1 || pos == 2 || pos == 4) begin
          chk("R7 check-bit data", {68'd0, rd_data}, {68'd0, 4'(d)});
          chk("R7 check-bit flags", {70'd0, rd_single, rd_double}, 72'd2);
        end else begin
          chk("R6 data-bit repaired", {68'd0, rd_data}, {68'd0, 4'(d)});
          chk("R6 data-bit flags", {70'd0, rd_single, rd_double}, 72'd2);
        end
        chk("R11 flags exclusive", {71'd0, rd_single & rd_double}, 72'd0);
      end
    end

    // R9: random double flips, data passed through raw
    for (int n = 0; n < 60; n++) begin
      logic [3:0] d;
      logic [7:0] c;
      int a, b;
      d = 4'($urandom);
      a = 1 + int'($urandom % 8);
      b = 1 + int'($urandom % 7);
      if (b >= a) b++;
      c = enc4(d) ^ flip_at(a) ^ flip_at(b);
      read4(d, c);
      chk("R9 double flags", {70'd0, rd_single, rd_double}, 72'd1);
      chk("R9 raw data", {68'd0, rd_data}, {68'd0, raw4(c)});
    end

    // R4 and R10 (combinational build): 64 data bits in 72
    for (int n = 0; n < 8; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      @(negedge clk);
      w_data = d;
      #1;
      chk("R4 wide even word", {71'd0, ^w_code}, 72'd0);
      w_rd = w_code;
      #1;
      chk("R10 R5 wide clean", {6'd0, w_single, w_double, w_out}, {8'd0, d});
      for (int i = 0; i < 72; i++) begin
        w_rd = w_code ^ (72'd1 << i);
        #1;
        chk("R4 wide single repaired", {6'd0, w_single, w_double, w_out}, {8'h02, d});
      end
      for (int m = 0; m < 6; m++) begin
        int a, b;
        a = int'($urandom % 72);
        b = int'($urandom % 71);
        if (b >= a) b++;
        w_rd = w_code ^ (72'd1 << a) ^ (72'd1 << b);
        #1;
        chk("R9 wide double", {70'd0, w_single, w_double}, 72'd1);
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule